// File: doc/BRIEF.md
# Byte-Select Synchronous Memory Port

This block is one access port of a synchronous static memory. Its word is split into byte lanes (two lanes of nine bits by default). At every rising clock edge the port looks at a pair of chip selects of opposite polarity, a read/write line and one active-low enable per lane. It then writes only the enabled lanes of the addressed word, or reads the addressed word and marks which lanes carry read data.

The read path is set by a parameter. In flow-through form, read data comes from a single register loaded at the access edge. In pipelined form a second register adds one cycle, and that register carries its own copy of the per-lane valid flags.

The port does not drive a bidirectional bus itself. It presents the read word together with one drive enable per lane, and the surrounding pad logic uses these enables for the tristate buffers. A lane enable that is low means that lane is at high impedance. The output enable input and the snooze input gate the lane drive enables directly, with no register in the way.

Top module: `bsp_port`

## Requirements
- R1: An access takes place only when `sel_lo_n` is 0 and `sel_hi` is 1 at the clock edge. With any other combination nothing is written, and no lane is driven for that cycle's read slot.
- R2: Lane 1 is data bits 17:9 and lane 0 is bits 8:0. A write (`rd_wr_n`=0) updates only the lanes whose `lane_en_n` bit is 0, and leaves the other lanes of the word unchanged.
- R3: With `lane_en_n`=2'b11 the cycle neither writes nor drives any lane.
- R4: A read marks lane i valid when `lane_en_n[i]`=0. `lane_oe[i]` is 1 only while that lane is valid and `oe_n` is 0, and `oe_n` acts in the same cycle it is applied.
- R5: In flow-through mode (PIPELINED=0), read data and lane valid flags appear on `rdata`/`lane_oe` in the cycle right after the access edge.
- R6: In pipelined mode (PIPELINED=1), read data and lane valid flags appear one cycle later than in flow-through mode, whatever is presented in between.
- R7: In pipelined mode `lane_oe` is 0 in any cycle in which `rd_wr_n` is 0.
- R8: In flow-through mode, the cycle after a write edge drives no lane.
- R9: While `rst_n` is 0, and after it until a read completes, `lane_oe` is 0.
- R10: While `snooze` is 1 no access is performed and `lane_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the read-path flags |
| sel_lo_n | input | 1 | Active-low chip select |
| sel_hi | input | 1 | Active-high chip select |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| lane_en_n | input | LANES | Active-low per-lane enables |
| oe_n | input | 1 | Active-low output enable, combinational gate |
| snooze | input | 1 | Suspends access and releases all lanes |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write word |
| rdata | output | LANES*LANE_W | Read word (valid where `lane_oe` is set) |
| lane_oe | output | LANES | Per-lane drive enable; 0 means high impedance |

## Verification
The hardest case to reach is a pipelined read whose data is still in flight while the inputs of the next cycle change beneath it. That next cycle may be a deselect, a write, a snooze or a raised output enable, and each must either gate the delayed lanes or leave them alone. The stimulus runs the flow-through and the pipelined port side by side on one vector stream. Reads are placed directly before writes, deselects and snooze cycles, so the pipelined port's expected lanes come from the previous vector, gated by the current one.

// File: rtl/bsp_pkg.sv
`timescale 1ns/1ps
package bsp_pkg;

   // decoded state of one clock edge
   typedef struct packed {
      logic sel;   // both chip selects active
      logic acc;   // selected and awake
      logic rd;    // read access
      logic wr;    // write access
   } bsp_acc_t;

   function automatic bsp_acc_t bsp_decode_f(input logic lo_n, input logic hi,
                                             input logic rw, input logic snz);
      bsp_acc_t a;
      a.sel = ~lo_n & hi;
      a.acc = a.sel & ~snz;
      a.rd  = a.acc & rw;
      a.wr  = a.acc & ~rw;
      return a;
   endfunction

endpackage

// File: rtl/bsp_decode.sv
`timescale 1ns/1ps
module bsp_decode
   import bsp_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic             sel_lo_n,
   input  logic             sel_hi,
   input  logic             rd_wr_n,
   input  logic [LANES-1:0] lane_en_n,
   input  logic             snooze,
   output bsp_acc_t         acc,
   output logic [LANES-1:0] wr_mask,
   output logic [LANES-1:0] rd_mask,
   output logic             rd_any
);

   logic [LANES-1:0] lane_on;

   always_comb begin
      acc     = bsp_decode_f(sel_lo_n, sel_hi, rd_wr_n, snooze);
      lane_on = ~lane_en_n;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign wr_mask[i] = acc.wr & lane_on[i];
      assign rd_mask[i] = acc.rd & lane_on[i];
   end

   assign rd_any = |rd_mask;

endmodule

// File: rtl/bsp_array.sv
`timescale 1ns/1ps
module bsp_array #(
   parameter int LANES  = 2,
   parameter int LANE_W = 9,
   parameter int ADDR_W = 4,
   localparam int DEPTH  = 1 << ADDR_W,
   localparam int WORD_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic [LANES-1:0]  wr_mask,
   input  logic              rd_any,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rq
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] rd_q;

      always_ff @(posedge clk) begin
         if (wr_mask[i])
            mem[addr] <= wdata[i*LANE_W +: LANE_W];
      end

      always_ff @(posedge clk) begin
         if (rd_any)
            rd_q <= mem[addr];
      end

      assign rq[i*LANE_W +: LANE_W] = rd_q;
   end

endmodule

// File: rtl/bsp_readpath.sv
`timescale 1ns/1ps
module bsp_readpath #(
   parameter int LANES     = 2,
   parameter int LANE_W    = 9,
   parameter bit PIPELINED = 1'b0,
   localparam int WORD_W   = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LANES-1:0]  rd_mask,
   input  logic [WORD_W-1:0] rq,
   output logic [WORD_W-1:0] q,
   output logic [LANES-1:0]  q_vld
);

   logic [LANES-1:0] s1_vld;

   always_ff @(posedge clk) begin
      if (!rst_n) s1_vld <= '0;
      else        s1_vld <= rd_mask;
   end

   if (PIPELINED) begin : g_pipe
      logic [WORD_W-1:0] s2_q;
      logic [LANES-1:0]  s2_vld;

      always_ff @(posedge clk) begin
         if (!rst_n) s2_vld <= '0;
         else        s2_vld <= s1_vld;
      end

      always_ff @(posedge clk) begin
         s2_q <= rq;
      end

      assign q     = s2_q;
      assign q_vld = s2_vld;
   end else begin : g_flow
      assign q     = rq;
      assign q_vld = s1_vld;
   end

endmodule

// File: rtl/bsp_port.sv
`timescale 1ns/1ps
module bsp_port
   import bsp_pkg::*;
#(
   parameter int LANES     = 2,
   parameter int LANE_W    = 9,
   parameter int ADDR_W    = 4,
   parameter bit PIPELINED = 1'b0,
   localparam int WORD_W   = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_lo_n,
   input  logic              sel_hi,
   input  logic              rd_wr_n,
   input  logic [LANES-1:0]  lane_en_n,
   input  logic              oe_n,
   input  logic              snooze,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata,
   output logic [LANES-1:0]  lane_oe
);

   if (LANES < 1 || LANES > 8) begin : g_bad_lanes
      $error("bsp_port: LANES must be 1..8");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("bsp_port: LANE_W must be positive");
   end
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr_w
      $error("bsp_port: ADDR_W must be 1..10");
   end

   bsp_acc_t          acc;
   logic [LANES-1:0]  wr_mask;
   logic [LANES-1:0]  rd_mask;
   logic              rd_any;
   logic [WORD_W-1:0] rq;
   logic [WORD_W-1:0] q;
   logic [LANES-1:0]  q_vld;
   logic              live;

   bsp_decode #(.LANES(LANES)) u_dec (
      .sel_lo_n (sel_lo_n),
      .sel_hi   (sel_hi),
      .rd_wr_n  (rd_wr_n),
      .lane_en_n(lane_en_n),
      .snooze   (snooze),
      .acc      (acc),
      .wr_mask  (wr_mask),
      .rd_mask  (rd_mask),
      .rd_any   (rd_any)
   );

   bsp_array #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_arr (
      .clk    (clk),
      .wr_mask(wr_mask),
      .rd_any (rd_any),
      .addr   (addr),
      .wdata  (wdata),
      .rq     (rq)
   );

   bsp_readpath #(.LANES(LANES), .LANE_W(LANE_W), .PIPELINED(PIPELINED)) u_rp (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_mask(rd_mask),
      .rq     (rq),
      .q      (q),
      .q_vld  (q_vld)
   );

   // live gating of the drive enables: output enable and snooze always,
   // and in pipelined form a write cycle releases the bus at once
   if (PIPELINED) begin : g_live_pipe
      assign live = ~oe_n & ~snooze & rd_wr_n;
   end else begin : g_live_flow
      assign live = ~oe_n & ~snooze;
   end

   assign lane_oe = q_vld & {LANES{live}};
   assign rdata   = q;

endmodule

// File: rtl/bsp_port_chk.sv
`timescale 1ns/1ps
module bsp_port_chk #(
   parameter int LANES     = 2,
   parameter bit PIPELINED = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sel_lo_n,
   input logic             sel_hi,
   input logic             rd_wr_n,
   input logic [LANES-1:0] lane_en_n,
   input logic             oe_n,
   input logic             snooze,
   input logic [LANES-1:0] lane_oe
);

   // R10
   snooze_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snooze |-> lane_oe == '0);

   // R4
   oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> lane_oe == '0);

   if (PIPELINED) begin : g_pipe
      // R7
      pipe_write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_wr_n |-> lane_oe == '0);

      // R1
      pipe_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_lo_n || !sel_hi) |=> ##1 lane_oe == '0);

      for (genvar i = 0; i < LANES; i++) begin : g_lane
         // R6
         pipe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lane_oe[i] |-> $past(rd_wr_n && !sel_lo_n && sel_hi && !snooze && !lane_en_n[i], 2));
      end
   end else begin : g_flow
      // R1
      flow_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_lo_n || !sel_hi) |=> lane_oe == '0);

      // R8
      flow_write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_wr_n |=> lane_oe == '0);

      // R3
      flow_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (&lane_en_n) |=> lane_oe == '0);

      for (genvar i = 0; i < LANES; i++) begin : g_lane
         // R5
         flow_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lane_oe[i] |-> $past(rd_wr_n && !sel_lo_n && sel_hi && !snooze && !lane_en_n[i], 1));
      end
   end

endmodule

bind bsp_port bsp_port_chk #(.LANES(LANES), .PIPELINED(PIPELINED)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel_lo_n (sel_lo_n),
   .sel_hi   (sel_hi),
   .rd_wr_n  (rd_wr_n),
   .lane_en_n(lane_en_n),
   .oe_n     (oe_n),
   .snooze   (snooze),
   .lane_oe  (lane_oe)
);

// File: tb/sim_bsp_port.sv
`timescale 1ns/1ps
module sim_bsp_port;

   localparam int NV = 18;

   typedef struct packed {
      logic        lo_n;
      logic        hi;
      logic        rw;
      logic [1:0]  ben;
      logic        oen;
      logic        snz;
      logic [3:0]  addr;
      logic [17:0] wd;
      logic [1:0]  ev;   // lanes valid after the edge (flow-through timing)
      logic [17:0] ed;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      '{1'b0,1'b1,1'b0,2'b00,1'b0,1'b0,4'd1,{9'h1A5,9'h05A},2'b00,18'd0},           // 0  R2 write both
      '{1'b0,1'b1,1'b1,2'b00,1'b0,1'b0,4'd1,18'd0,2'b11,{9'h1A5,9'h05A}},           // 1  R5 read both
      '{1'b0,1'b1,1'b0,2'b10,1'b0,1'b0,4'd1,{9'h0FF,9'h123},2'b00,18'd0},           // 2  R8 write lane0
      '{1'b0,1'b1,1'b1,2'b01,1'b0,1'b0,4'd1,18'd0,2'b10,{9'h1A5,9'h000}},           // 3  R4 read lane1
      '{1'b0,1'b1,1'b1,2'b10,1'b1,1'b0,4'd1,18'd0,2'b01,{9'h000,9'h123}},           // 4  R4 oe high
      '{1'b0,1'b1,1'b0,2'b00,1'b0,1'b0,4'd2,{9'h0AA,9'h155},2'b00,18'd0},           // 5  R2
      '{1'b0,1'b1,1'b0,2'b01,1'b0,1'b0,4'd2,{9'h1C3,9'h000},2'b00,18'd0},           // 6  R2 write lane1
      '{1'b0,1'b1,1'b1,2'b00,1'b0,1'b0,4'd2,18'd0,2'b11,{9'h1C3,9'h155}},           // 7  R2 merged word
      '{1'b1,1'b1,1'b1,2'b00,1'b0,1'b0,4'd2,18'd0,2'b00,18'd0},                     // 8  R1
      '{1'b0,1'b0,1'b1,2'b00,1'b0,1'b0,4'd2,18'd0,2'b00,18'd0},                     // 9  R1
      '{1'b1,1'b1,1'b0,2'b00,1'b0,1'b0,4'd2,18'd0,2'b00,18'd0},                     // 10 R1 desel write
      '{1'b0,1'b1,1'b1,2'b00,1'b0,1'b0,4'd2,18'd0,2'b11,{9'h1C3,9'h155}},           // 11 R1
      '{1'b0,1'b1,1'b0,2'b00,1'b0,1'b1,4'd2,{9'h1FF,9'h1FF},2'b00,18'd0},           // 12 R10
      '{1'b0,1'b1,1'b1,2'b00,1'b0,1'b1,4'd2,18'd0,2'b00,18'd0},                     // 13 R10
      '{1'b0,1'b1,1'b1,2'b00,1'b0,1'b0,4'd2,18'd0,2'b11,{9'h1C3,9'h155}},           // 14 R10
      '{1'b0,1'b1,1'b1,2'b11,1'b0,1'b0,4'd2,18'd0,2'b00,18'd0},                     // 15 R3
      '{1'b0,1'b1,1'b0,2'b11,1'b0,1'b0,4'd2,18'd0,2'b00,18'd0},                     // 16 R3
      '{1'b0,1'b1,1'b1,2'b00,1'b0,1'b0,4'd2,18'd0,2'b11,{9'h1C3,9'h155}}            // 17 R3
   };

   localparam string TAGS [NV] = '{"R2","R5","R8","R4","R4","R2","R2","R2","R1",
                                   "R1","R1","R1","R10","R10","R10","R3","R3","R3"};

   logic        clk = 1'b0;
   logic        rst_n;
   logic        lo_n, hi, rw, oen, snz;
   logic [1:0]  ben;
   logic [3:0]  addr;
   logic [17:0] wd;
   logic [17:0] rd0, rd1;
   logic [1:0]  oe0, oe1;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   bsp_port #(.PIPELINED(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .sel_lo_n(lo_n), .sel_hi(hi), .rd_wr_n(rw),
      .lane_en_n(ben), .oe_n(oen), .snooze(snz), .addr(addr), .wdata(wd),
      .rdata(rd0), .lane_oe(oe0));

   bsp_port #(.PIPELINED(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .sel_lo_n(lo_n), .sel_hi(hi), .rd_wr_n(rw),
      .lane_en_n(ben), .oe_n(oen), .snooze(snz), .addr(addr), .wdata(wd),
      .rdata(rd1), .lane_oe(oe1));

   function automatic logic [17:0] lane_mask(input logic [1:0] en);
      return {{9{en[1]}}, {9{en[0]}}};
   endfunction

   task automatic check(input string req, input string what,
                        input logic [1:0] got_en, input logic [17:0] got_d,
                        input logic [1:0] exp_en, input logic [17:0] exp_d);
      logic [17:0] m;
      m = lane_mask(exp_en);
      checks++;
      if (got_en !== exp_en || (got_d & m) !== (exp_d & m)) begin
         errors++;
         $display("FAIL %s %s: lane_oe=%b data=%h, expected lane_oe=%b data=%h",
                  req, what, got_en, got_d & m, exp_en, exp_d & m);
      end
   endtask

   task automatic idle();
      lo_n = 1'b1; hi = 1'b0; rw = 1'b1; ben = 2'b11;
      oen = 1'b0; snz = 1'b0; addr = '0; wd = '0;
   endtask

   task automatic drive(input logic l, input logic h, input logic r,
                        input logic [1:0] b, input logic o, input logic s,
                        input logic [3:0] a, input logic [17:0] d);
      lo_n = l; hi = h; rw = r; ben = b; oen = o; snz = s; addr = a; wd = d;
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [1:0]  pv;
      logic [17:0] pd;
      logic [1:0]  e1;
      rst_n = 1'b0;
      idle();
      repeat (3) @(posedge clk);
      #1;
      // R9 reset state
      check("R9", "flow in reset", oe0, rd0, 2'b00, 18'd0);
      check("R9", "pipe in reset", oe1, rd1, 2'b00, 18'd0);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;
      check("R9", "flow after reset", oe0, rd0, 2'b00, 18'd0);
      check("R9", "pipe after reset", oe1, rd1, 2'b00, 18'd0);

      pv = 2'b00; pd = '0;
      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         drive(VECS[k].lo_n, VECS[k].hi, VECS[k].rw, VECS[k].ben,
               VECS[k].oen, VECS[k].snz, VECS[k].addr, VECS[k].wd);
         @(posedge clk); #1;
         check(TAGS[k], $sformatf("flow vector %0d", k), oe0, rd0,
               VECS[k].ev & {2{~VECS[k].oen}}, VECS[k].ed);
         // R6 R7: pipelined port shows the previous vector's read, live gated
         e1 = pv & {2{~VECS[k].oen & ~VECS[k].snz & VECS[k].rw}};
         check(VECS[k].rw ? "R6" : "R7", $sformatf("pipe vector %0d", k), oe1, rd1, e1, pd);
         pv = VECS[k].ev; pd = VECS[k].ed;
      end

      // R6: read, then a deselected read-level cycle; pipe shows data late
      @(negedge clk) drive(1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 4'd1, 18'd0);
      @(posedge clk); #1;
      check("R5", "flow read addr1", oe0, rd0, 2'b11, {9'h1A5, 9'h123});
      @(negedge clk) drive(1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 4'd0, 18'd0);
      @(posedge clk); #1;
      check("R1", "flow deselect after read", oe0, rd0, 2'b00, 18'd0);
      check("R6", "pipe delayed read addr1", oe1, rd1, 2'b11, {9'h1A5, 9'h123});
      @(posedge clk); #1;
      check("R6", "pipe drains after deselect", oe1, rd1, 2'b00, 18'd0);

      // R7: read followed by a deselected write-level cycle
      @(negedge clk) drive(1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 4'd2, 18'd0);
      @(posedge clk);
      @(negedge clk) drive(1'b1, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 4'd0, 18'd0);
      @(posedge clk); #1;
      check("R7", "pipe released by write level", oe1, rd1, 2'b00, 18'd0);
      @(negedge clk) rw = 1'b1;
      #1;
      check("R7", "pipe lane back when write level drops", oe1, rd1, 2'b11, {9'h1C3, 9'h155});

      // R4: oe_n gates combinationally
      @(negedge clk) drive(1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 4'd2, 18'd0);
      @(posedge clk); #1;
      oen = 1'b1; #1;
      check("R4", "flow oe_n raised mid cycle", oe0, rd0, 2'b00, 18'd0);
      oen = 1'b0; #1;
      check("R4", "flow oe_n lowered mid cycle", oe0, rd0, 2'b11, {9'h1C3, 9'h155});

      // R9: reset clears a pending read
      @(negedge clk) begin
         drive(1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 4'd2, 18'd0);
         rst_n = 1'b0;
      end
      @(posedge clk); #1;
      check("R9", "flow reset over read", oe0, rd0, 2'b00, 18'd0);
      check("R9", "pipe reset over read", oe1, rd1, 2'b00, 18'd0);
      @(negedge clk) begin rst_n = 1'b1; idle(); end
      @(posedge clk); #1;
      check("R9", "pipe after second reset", oe1, rd1, 2'b00, 18'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule